// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out the 32-bit atomic instructions of a RISC-V style integer core. It handles the load-reserved and store-conditional pair and nine read-modify-write operations: swap, add, xor, and, or, and the signed and unsigned minimum and maximum. The core hands over the instruction word together with the values of the two source registers. The unit then runs the memory traffic through a single-port request interface. At the end it presents the value destined for rd, with a one-cycle completion pulse.

The unit works on one instruction at a time. `req_ready` is high only while the sequencer sits in IDLE. An instruction is taken on a clock edge where `req_valid` and `req_ready` are both high. The sequencer then moves through its states:

- IDLE goes to DISPATCH when an instruction is taken.
- DISPATCH classifies the latched word:
  - an illegal word goes straight to DONE;
  - a load-reserved or a read-modify-write goes to READ;
  - a store-conditional that hits the reservation goes to WRITE;
  - a store-conditional that misses goes to DONE.
- READ holds a read request until the memory signals ready. A load-reserved then goes to DONE; a read-modify-write goes to WRITE.
- WRITE holds a write request until ready and then goes to DONE.
- DONE raises `done` for one cycle and returns to IDLE.

One reservation register holds a single word address. A load-reserved sets it. Any store-conditional, whether it succeeds or fails, clears it.

Top module: `amo_unit`

## Requirements
- R1: An instruction is legal only if bits [6:0] equal 7'b0101111 and bits [14:12] equal 3'b010. Any other word completes with `illegal`=1 and `rd_data`=0, and makes no memory access.
- R2: Bits [31:27] select the operation:
  - 00010 is load-reserved and 00011 is store-conditional;
  - 00001 is swap, 00000 add, 00100 xor, 01100 and, 01000 or;
  - 10000 is signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max.
  Any other selector completes as illegal, with no memory access.
- R3: A load-reserved whose rs2 field (bits [24:20]) is not zero completes as illegal and makes no memory access.
- R4: A load-reserved makes one read at the rs1 value, returns the word read in `rd_data`, and records that address as reserved.
- R5: A store-conditional whose rs1 address matches a valid reservation writes the rs2 value to that address and returns 0. It also clears the reservation, so an immediate repeat fails.
- R6: A store-conditional without a matching valid reservation makes no memory access and returns 1. It still clears any reservation.
- R7: A new load-reserved replaces the earlier reservation, so only the most recently reserved address can succeed.
- R8: Swap, add, xor, and and or each do the following:
  - read the word at rs1 and return the old word in `rd_data`;
  - then write back, respectively, rs2, old+rs2, old^rs2, old&rs2 or old|rs2.
- R9: Min and max write back the smaller or larger of the old word and rs2 under signed comparison; the unsigned variants use unsigned comparison. All four return the old word.
- R10: A memory request is held steady until `mem_ready` is seen, with address, and for writes data, unchanged. Read and write are never requested together. The address is always the rs1 value.
- R11: `done` is a single-cycle pulse, one per accepted instruction. `req_ready` falls on the cycle after acceptance and stays low until the sequencer is back in IDLE.
- R12: After reset the unit is idle with `req_ready`=1, no memory request and no `done`. The reservation is invalid, so a store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle and able to take an instruction |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of source register 1 (memory address) |
| rs2_val | input | XLEN | Value of source register 2 |
| done | output | 1 | One-cycle pulse: result valid |
| rd_data | output | XLEN | Result for the destination register |
| illegal | output | 1 | Completed instruction was illegal (valid with done) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | XLEN | Word address of the request |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current request |

## Verification
The hardest behaviour to reach is a reservation lost silently. Three cases matter:
- a failed store-conditional to another address, which must still clear the reservation;
- a second load-reserved, which must displace the first;
- a successful store-conditional, which must leave nothing behind for a repeat.

Each shows only as a later store-conditional returning 1, with no write reaching memory. The stimulus therefore chains load-reserved and store-conditional pairs across two or three addresses in specific orders. Each step is checked for its return code, the memory word and the number of memory accesses it made. The memory model's latency changes between instructions, so that the request-hold behaviour is exercised with zero and with several wait cycles.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int unsigned ILEN = 32;
    localparam logic [6:0] AMO_MAJOR = 7'b0101111;
    localparam logic [2:0] AMO_WORD  = 3'b010;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SWAP = 5'b00001,
        OP_LR   = 5'b00010,
        OP_SC   = 5'b00011,
        OP_XOR  = 5'b00100,
        OP_OR   = 5'b01000,
        OP_AND  = 5'b01100,
        OP_MIN  = 5'b10000,
        OP_MAX  = 5'b10100,
        OP_MINU = 5'b11000,
        OP_MAXU = 5'b11100
    } amo_op_e;

    typedef enum logic [1:0] {
        K_RMW,
        K_LR,
        K_SC,
        K_BAD
    } amo_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DISPATCH,
        S_READ,
        S_WRITE,
        S_DONE
    } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [6:0] major,
    input  logic [2:0] width,
    input  logic [4:0] sel,
    input  logic [4:0] src2_field,
    output amo_kind_e  kind,
    output amo_op_e    op
);

    always_comb begin
        op   = amo_op_e'(sel);
        kind = K_BAD;
        if (major == AMO_MAJOR && width == AMO_WORD) begin
            case (sel)
                OP_LR:   kind = (src2_field == 5'd0) ? K_LR : K_BAD;
                OP_SC:   kind = K_SC;
                OP_ADD, OP_SWAP, OP_XOR, OP_OR, OP_AND,
                OP_MIN, OP_MAX, OP_MINU, OP_MAXU:
                         kind = K_RMW;
                default: kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  amo_op_e        op,
    input  logic [W-1:0]   old_word,
    input  logic [W-1:0]   src,
    output logic [W-1:0]   result
);

    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(old_word) < $signed(src);
    assign lt_unsigned = old_word < src;

    always_comb begin
        case (op)
            OP_SWAP: result = src;
            OP_ADD:  result = old_word + src;
            OP_XOR:  result = old_word ^ src;
            OP_AND:  result = old_word & src;
            OP_OR:   result = old_word | src;
            OP_MIN:  result = lt_signed   ? old_word : src;
            OP_MAX:  result = lt_signed   ? src : old_word;
            OP_MINU: result = lt_unsigned ? old_word : src;
            OP_MAXU: result = lt_unsigned ? src : old_word;
            default: result = src;
        endcase
    end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] set_addr,
    input  logic [W-1:0] probe_addr,
    output logic         hit
);

    logic         held_q;
    logic [W-1:0] where_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= 1'b0;
            where_q <= '0;
        end else if (set) begin
            held_q  <= 1'b1;
            where_q <= set_addr;
        end else if (clr) begin
            held_q  <= 1'b0;
        end
    end

    assign hit = held_q && (where_q == probe_addr);

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  amo_kind_e kind,
    input  logic      resv_hit,
    input  logic      mem_ready,
    output logic      busy,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      done,
    output logic      cap_old,
    output logic      resv_set,
    output logic      resv_clr,
    output logic      sc_pass,
    output logic      flag_bad
);

    amo_state_e state_q;
    amo_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_DISPATCH;
            end
            S_DISPATCH: begin
                unique case (kind)
                    K_BAD:       state_d = S_DONE;
                    K_SC:        state_d = resv_hit ? S_WRITE : S_DONE;
                    K_LR, K_RMW: state_d = S_READ;
                endcase
            end
            S_READ: begin
                if (mem_ready) state_d = (kind == K_LR) ? S_DONE : S_WRITE;
            end
            S_WRITE: begin
                if (mem_ready) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        done     = 1'b0;
        cap_old  = 1'b0;
        resv_set = 1'b0;
        resv_clr = 1'b0;
        sc_pass  = 1'b0;
        flag_bad = 1'b0;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_DISPATCH: begin
                flag_bad = (kind == K_BAD);
                resv_clr = (kind == K_SC);
                sc_pass  = (kind == K_SC) && resv_hit;
            end
            S_READ: begin
                mem_rd   = 1'b1;
                cap_old  = mem_ready;
                resv_set = mem_ready && (kind == K_LR);
            end
            S_WRITE: mem_wr = 1'b1;
            S_DONE:  done   = 1'b1;
            default: busy   = 1'b1;
        endcase
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic            done,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready
);

    logic            busy;
    logic            start;
    logic            cap_old;
    logic            resv_set;
    logic            resv_clr;
    logic            resv_hit;
    logic            sc_pass;
    logic            flag_bad;
    logic            seq_done;
    amo_kind_e       kind;
    amo_op_e         op;
    logic [XLEN-1:0] alu_res;

    logic [6:0]      major_q;
    logic [2:0]      width_q;
    logic [4:0]      sel_q;
    logic [4:0]      src2f_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] src_q;
    logic [XLEN-1:0] result_q;
    logic            bad_q;

    logic            unused_fields;
    assign unused_fields = ^{instr[26:25], instr[11:7]};

    assign start = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            major_q  <= '0;
            width_q  <= '0;
            sel_q    <= '0;
            src2f_q  <= '0;
            addr_q   <= '0;
            src_q    <= '0;
            result_q <= '0;
            bad_q    <= 1'b0;
        end else begin
            if (start) begin
                major_q  <= instr[6:0];
                width_q  <= instr[14:12];
                sel_q    <= instr[31:27];
                src2f_q  <= instr[24:20];
                addr_q   <= rs1_val;
                src_q    <= rs2_val;
                result_q <= '0;
                bad_q    <= 1'b0;
            end
            if (flag_bad) begin
                bad_q    <= 1'b1;
                result_q <= '0;
            end
            if (resv_clr) begin
                result_q <= {{(XLEN-1){1'b0}}, !sc_pass};
            end
            if (cap_old) begin
                result_q <= mem_rdata;
            end
        end
    end

    amo_decode u_decode (
        .major      (major_q),
        .width      (width_q),
        .sel        (sel_q),
        .src2_field (src2f_q),
        .kind       (kind),
        .op         (op)
    );

    amo_alu #(.W(XLEN)) u_alu (
        .op       (op),
        .old_word (result_q),
        .src      (src_q),
        .result   (alu_res)
    );

    amo_resv #(.W(XLEN)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (resv_set),
        .clr        (resv_clr),
        .set_addr   (addr_q),
        .probe_addr (addr_q),
        .hit        (resv_hit)
    );

    amo_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .resv_hit  (resv_hit),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .done      (seq_done),
        .cap_old   (cap_old),
        .resv_set  (resv_set),
        .resv_clr  (resv_clr),
        .sc_pass   (sc_pass),
        .flag_bad  (flag_bad)
    );

    assign req_ready = !busy;
    assign done      = seq_done;
    assign rd_data   = result_q;
    assign illegal   = seq_done && bad_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = (kind == K_SC) ? src_q : alu_res;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            done,
    input logic            illegal,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready
);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd && !mem_wr && !done));

    assert_illegal_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .illegal   (illegal),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic [XLEN-1:0] rs2_val = '0;
    logic            done;
    logic [XLEN-1:0] rd_data;
    logic            illegal;
    logic            mem_rd;
    logic            mem_wr;
    logic [XLEN-1:0] mem_addr;
    logic [XLEN-1:0] mem_wdata;
    logic [XLEN-1:0] mem_rdata;
    logic            mem_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit #(.XLEN(XLEN)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .instr     (instr),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .done      (done),
        .rd_data   (rd_data),
        .illegal   (illegal),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [31:0] seed(input int i);
        return 32'h1357_0000 + i * 32'h0000_0111;
    endfunction

    // memory model with programmable wait cycles
    logic [31:0] mem [16];
    int          lat = 0;
    int          wcnt;
    int          acc_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
            acc_cnt   <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= seed(i);
        end else if ((mem_rd || mem_wr) && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready <= 1'b1;
                wcnt      <= 0;
                acc_cnt   <= acc_cnt + 1;
                if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[5:2]];
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model and scoreboard
    typedef struct {
        string       req;
        logic [31:0] rd;
        logic        ill;
        int          idx;
        logic [31:0] mv;
        int          acc;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] refmem [16];
    logic        rv = 1'b0;
    logic [31:0] ra = '0;

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic [4:0] r2,
                                       input logic [2:0] w, input logic [6:0] opc);
        return {f5, 2'b00, r2, 5'd10, w, 5'd11, opc};
    endfunction

    task automatic issue(input string req, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b);
        exp_t        e;
        logic [4:0]  f5;
        logic [31:0] old;
        logic        ok;
        int          ix;
        ix  = int'(a[5:2]);
        f5  = ins[31:27];
        old = refmem[ix];
        ok  = (ins[6:0] == 7'b0101111) && (ins[14:12] == 3'b010);
        e.req = req; e.idx = ix; e.ill = 1'b0; e.rd = '0; e.acc = 0;
        if (ok && f5 == 5'b00010 && ins[24:20] == 5'd0) begin
            e.rd = old; e.acc = 1; rv = 1'b1; ra = a;
        end else if (ok && f5 == 5'b00011) begin
            if (rv && ra == a) begin
                refmem[ix] = b; e.rd = 0; e.acc = 1;
            end else begin
                e.rd = 1;
            end
            rv = 1'b0;
        end else if (ok && (f5 == 5'b00001 || f5 == 5'b00000 || f5 == 5'b00100 ||
                            f5 == 5'b01100 || f5 == 5'b01000 || f5 == 5'b10000 ||
                            f5 == 5'b10100 || f5 == 5'b11000 || f5 == 5'b11100)) begin
            e.rd = old; e.acc = 2;
            case (f5)
                5'b00001: refmem[ix] = b;
                5'b00000: refmem[ix] = old + b;
                5'b00100: refmem[ix] = old ^ b;
                5'b01100: refmem[ix] = old & b;
                5'b01000: refmem[ix] = old | b;
                5'b10000: refmem[ix] = ($signed(old) <= $signed(b)) ? old : b;
                5'b10100: refmem[ix] = ($signed(old) >= $signed(b)) ? old : b;
                5'b11000: refmem[ix] = (old <= b) ? old : b;
                default:  refmem[ix] = (old >= b) ? old : b;
            endcase
        end else begin
            e.ill = 1'b1;
        end
        e.mv = refmem[ix];
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11", "req_ready after accept", {31'b0, req_ready}, 32'd0);
    endtask

    // monitor
    int   acc_seen = 0;
    logic prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) begin
                check("R11", "done held two cycles", 32'd1, 32'd0);
            end else if (done) begin
                if (sb.size() == 0) begin
                    check("R11", "done with nothing pending", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, "rd_data", rd_data, e.rd);
                    check(e.req, "illegal", {31'b0, illegal}, {31'b0, e.ill});
                    check(e.req, "memory word", mem[e.idx], e.mv);
                    check(e.req, "access count", acc_cnt - acc_seen, e.acc);
                    acc_seen = acc_cnt;
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11: watchdog expired, actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [6:0] MAJ = 7'b0101111;
    localparam logic [2:0] WD  = 3'b010;

    initial begin
        for (int i = 0; i < 16; i++) refmem[i] = seed(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "req_ready", {31'b0, req_ready}, 32'd1);
        check("R12", "done", {31'b0, done}, 32'd0);
        check("R12", "mem_rd", {31'b0, mem_rd}, 32'd0);
        check("R12", "mem_wr", {31'b0, mem_wr}, 32'd0);

        // reservation invalid after reset
        issue("R12", mk(5'b00011, 5'd2, WD, MAJ), 32'h10, 32'hAAAA_0001);
        // LR then SC success then repeat fails
        lat = 2;
        issue("R4", mk(5'b00010, 5'd0, WD, MAJ), 32'h10, 32'h0);
        issue("R5", mk(5'b00011, 5'd2, WD, MAJ), 32'h10, 32'hCAFE_F00D);
        issue("R5", mk(5'b00011, 5'd2, WD, MAJ), 32'h10, 32'h1111_2222);
        // failed SC elsewhere clears the reservation
        lat = 0;
        issue("R4", mk(5'b00010, 5'd0, WD, MAJ), 32'h14, 32'h0);
        issue("R6", mk(5'b00011, 5'd2, WD, MAJ), 32'h18, 32'h3333_4444);
        issue("R6", mk(5'b00011, 5'd2, WD, MAJ), 32'h14, 32'h5555_6666);
        // newer LR replaces older
        lat = 1;
        issue("R7", mk(5'b00010, 5'd0, WD, MAJ), 32'h20, 32'h0);
        issue("R7", mk(5'b00010, 5'd0, WD, MAJ), 32'h24, 32'h0);
        issue("R7", mk(5'b00011, 5'd2, WD, MAJ), 32'h20, 32'h7777_8888);
        issue("R7", mk(5'b00010, 5'd0, WD, MAJ), 32'h20, 32'h0);
        issue("R7", mk(5'b00010, 5'd0, WD, MAJ), 32'h24, 32'h0);
        issue("R7", mk(5'b00011, 5'd2, WD, MAJ), 32'h24, 32'h9999_AAAA);
        // read-modify-write group
        lat = 3;
        issue("R8", mk(5'b00001, 5'd2, WD, MAJ), 32'h08, 32'h0F0F_1234);
        issue("R8", mk(5'b00000, 5'd2, WD, MAJ), 32'h08, 32'hF0F1_0001);
        lat = 0;
        issue("R8", mk(5'b00100, 5'd2, WD, MAJ), 32'h08, 32'hFFFF_0000);
        issue("R8", mk(5'b01100, 5'd2, WD, MAJ), 32'h08, 32'h00FF_FF00);
        issue("R8", mk(5'b01000, 5'd2, WD, MAJ), 32'h08, 32'h8000_0001);
        // signed and unsigned min/max
        lat = 1;
        issue("R9", mk(5'b00001, 5'd2, WD, MAJ), 32'h30, 32'hFFFF_FFF0);
        issue("R9", mk(5'b10000, 5'd2, WD, MAJ), 32'h30, 32'h0000_0005);
        issue("R9", mk(5'b10100, 5'd2, WD, MAJ), 32'h30, 32'h0000_0005);
        issue("R9", mk(5'b11000, 5'd2, WD, MAJ), 32'h30, 32'hFFFF_FFF0);
        issue("R9", mk(5'b11100, 5'd2, WD, MAJ), 32'h30, 32'hFFFF_FFF0);
        issue("R9", mk(5'b10000, 5'd2, WD, MAJ), 32'h30, 32'h7FFF_FFFF);
        issue("R9", mk(5'b10100, 5'd2, WD, MAJ), 32'h30, 32'h8000_0000);
        // illegal words
        issue("R1", mk(5'b00000, 5'd2, WD, 7'b0110011), 32'h0C, 32'h1);
        issue("R1", mk(5'b00000, 5'd2, 3'b000, MAJ), 32'h0C, 32'h1);
        issue("R2", mk(5'b00101, 5'd2, WD, MAJ), 32'h0C, 32'h1);
        issue("R2", mk(5'b11111, 5'd2, WD, MAJ), 32'h0C, 32'h1);
        issue("R3", mk(5'b00010, 5'd3, WD, MAJ), 32'h0C, 32'h0);
        issue("R3", mk(5'b00011, 5'd2, WD, MAJ), 32'h0C, 32'h2);
        // address taken from rs1 directly
        lat = 2;
        issue("R10", mk(5'b00000, 5'd2, WD, MAJ), 32'h3C, 32'h0000_0100);
        issue("R10", mk(5'b00001, 5'd2, WD, MAJ), 32'h00, 32'hDEAD_BEEF);

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule